// File: doc/BRIEF.md
# Y-Step Holding Line Rasteriser

This block walks the straight line between two signed pixel coordinates with an integer error term. It puts out one coordinate per clock, together with a valid strobe, from the start point to the end point inclusive. It covers every octant, plus horizontal, vertical and single-point lines. A run enable pauses the walk without losing its place.

Edge walkers for filled shapes need two instances that advance row by row together. For that, the block can be told to hold each time its next step would change the Y coordinate. While it holds, the pixel for the new row stays inside the block. Dropping the stop enable releases it in the same cycle. A configuration bit, captured at start, makes the block also hold straight after its first pixel. A single-cycle pulse marks the end of a line.

The controller has three states:
- `LN_IDLE`: waiting for a start.
- `LN_DRAW`: walking the line.
- `LN_HOLD`: waiting at a row boundary, or after the first pixel.

It has five transitions:
- `T_START`: IDLE to DRAW, when a start arrives.
- `T_STEP`: DRAW to DRAW, when a pixel is emitted with no stop due.
- `T_STOP`: DRAW or HOLD to HOLD, when a pixel is emitted and a stop is due.
- `T_RELEASE`: HOLD to DRAW, when the held pixel is emitted after the stop enable drops.
- `T_LAST`: DRAW or HOLD to IDLE, when the end pixel is emitted.

Top module: `ystep_line_raster`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, valid, done and the Y-stopped flag are all low. Reset is asynchronous and active low, and asserting it in mid-line abandons the line at once.
- R2: Coordinates are two's-complement values, CW bits wide (default 12). The emitted pixels are the integer Bresenham sequence for the given endpoints:
  - set dx = |x1-x0|, dy = -|y1-y0| and err = dx+dy;
  - on each step let e2 = 2*err;
  - if e2 >= dy, then err += dy and x moves one toward x1;
  - if e2 <= dx, then err += dx and y moves one toward y1.
  The sequence starts at (x0,y0), ends at (x1,y1) and holds max(|x1-x0|,|y1-y0|)+1 pixels.
- R3: Busy is low in the cycle in which a start is accepted in idle and high from the next cycle on. When run is enabled, the first pixel is valid in that next cycle.
- R4: Done is high for exactly one cycle, the cycle after the end pixel was emitted. Busy is already low in that cycle.
- R5: A start received while busy is ignored, and the current line goes on unchanged.
- R6: While run enable is low, no pixel is emitted and the walk keeps its position.
- R7: When stop-on-Y is enabled, or when the pixel was just released from a hold, emitting a pixel whose successor has a different Y puts the block into hold. While the Y-stopped flag is high, no pixel is emitted. Each pixel emitted while stop-on-Y is high has the Y of the pixel before it.
- R8: The Y-stopped flag falls in the same cycle as the stop-on-Y input goes low. In that cycle the held pixel is emitted, provided run is enabled.
- R9: If the hold-first bit is high at start, the block also holds after its first pixel, even when that pixel's successor is on the same row. The bit has no effect while stop-on-Y is low.
- R10: No pixel is valid while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a line (taken only when idle) |
| x0_i | input | CW | Start X, signed |
| y0_i | input | CW | Start Y, signed |
| x1_i | input | CW | End X, signed |
| y1_i | input | CW | End Y, signed |
| run_en_i | input | 1 | Allow a pixel to be emitted this cycle |
| ystop_en_i | input | 1 | Hold at Y changes; low releases a hold |
| hold_first_i | input | 1 | Also hold after the first pixel (captured at start) |
| pix_x_o | output | CW | Pixel X, signed |
| pix_y_o | output | CW | Pixel Y, signed |
| pix_valid_o | output | 1 | Pixel coordinate is valid this cycle |
| busy_o | output | 1 | A line is in progress |
| ystopped_o | output | 1 | Held at a row boundary |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A start is taken at a clock edge, so busy and the first pixel are checked in the cycle that follows. The done pulse is due one cycle after the end pixel and must be gone one cycle later. Valid and the Y-stopped flag respond within the same cycle to the run enable and the stop enable. The bench therefore changes its inputs on the falling edge and samples the outputs a short delay later, while those inputs are still steady. A release, for example, is checked in the very cycle the stop enable drops. Every valid pixel is compared with a Bresenham walk kept by the bench, which advances only when a pixel is accepted. Pauses, holds and ignored starts therefore show up as sequence errors wherever they go wrong.

// File: rtl/ystep_line_pkg.sv
`timescale 1ns/1ps
package ystep_line_pkg;
    typedef enum logic [1:0] {
        LN_IDLE = 2'd0,
        LN_DRAW = 2'd1,
        LN_HOLD = 2'd2
    } ln_state_e;
endpackage

// File: rtl/ystep_line_setup.sv
`timescale 1ns/1ps
// Endpoint preparation: absolute deltas, step directions, initial error term.
module ystep_line_setup #(
    parameter int CW = 12,
    parameter int EW = CW + 3
) (
    input  logic signed [CW-1:0] x0_i,
    input  logic signed [CW-1:0] y0_i,
    input  logic signed [CW-1:0] x1_i,
    input  logic signed [CW-1:0] y1_i,
    output logic signed [EW-1:0] dx_o,
    output logic signed [EW-1:0] dy_o,
    output logic signed [EW-1:0] err_o,
    output logic                 sxn_o,
    output logic                 syn_o
);
    logic signed [EW-1:0] ddx;
    logic signed [EW-1:0] ddy;

    always_comb begin
        ddx   = $signed({{(EW-CW){x1_i[CW-1]}}, x1_i}) - $signed({{(EW-CW){x0_i[CW-1]}}, x0_i});
        ddy   = $signed({{(EW-CW){y1_i[CW-1]}}, y1_i}) - $signed({{(EW-CW){y0_i[CW-1]}}, y0_i});
        sxn_o = ddx[EW-1];
        syn_o = ddy[EW-1];
        // dx is kept positive and dy negative
        dx_o  = sxn_o ? -ddx : ddx;
        dy_o  = syn_o ? ddy : -ddy;
        err_o = dx_o + dy_o;
    end
endmodule

// File: rtl/ystep_line_step.sv
`timescale 1ns/1ps
// One Bresenham step from the current position and error term.
module ystep_line_step #(
    parameter int CW = 12,
    parameter int EW = CW + 3
) (
    input  logic signed [CW-1:0] cx_i,
    input  logic signed [CW-1:0] cy_i,
    input  logic signed [EW-1:0] err_i,
    input  logic signed [EW-1:0] dx_i,
    input  logic signed [EW-1:0] dy_i,
    input  logic                 sxn_i,
    input  logic                 syn_i,
    output logic signed [CW-1:0] nx_o,
    output logic signed [CW-1:0] ny_o,
    output logic signed [EW-1:0] nerr_o,
    output logic                 y_moves_o
);
    localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};

    logic signed [EW:0] e2;
    logic               take_x;
    logic               take_y;

    always_comb begin
        e2        = $signed({err_i, 1'b0});
        take_x    = e2 >= $signed({dy_i[EW-1], dy_i});
        take_y    = e2 <= $signed({dx_i[EW-1], dx_i});
        nerr_o    = err_i + (take_x ? dy_i : '0) + (take_y ? dx_i : '0);
        nx_o      = take_x ? (sxn_i ? cx_i - C_ONE : cx_i + C_ONE) : cx_i;
        ny_o      = take_y ? (syn_i ? cy_i - C_ONE : cy_i + C_ONE) : cy_i;
        y_moves_o = take_y;
    end
endmodule

// File: rtl/ystep_line_raster.sv
`timescale 1ns/1ps
// Line rasteriser with optional hold at every Y step.
module ystep_line_raster #(
    parameter int CW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic signed [CW-1:0] x0_i,
    input  logic signed [CW-1:0] y0_i,
    input  logic signed [CW-1:0] x1_i,
    input  logic signed [CW-1:0] y1_i,
    input  logic                 run_en_i,
    input  logic                 ystop_en_i,
    input  logic                 hold_first_i,
    output logic signed [CW-1:0] pix_x_o,
    output logic signed [CW-1:0] pix_y_o,
    output logic                 pix_valid_o,
    output logic                 busy_o,
    output logic                 ystopped_o,
    output logic                 done_o
);
    import ystep_line_pkg::*;

    localparam int EW = CW + 3;

    ln_state_e state_q, state_d;

    logic signed [CW-1:0] cx_q, cy_q, ex_q, ey_q;
    logic signed [EW-1:0] err_q, dx_q, dy_q;
    logic                 sxn_q, syn_q;
    logic                 first_q, hfirst_q, done_q;

    logic signed [EW-1:0] s_dx, s_dy, s_err;
    logic                 s_sxn, s_syn;
    logic signed [CW-1:0] n_x, n_y;
    logic signed [EW-1:0] n_err;
    logic                 n_ymove;

    logic emit, at_end, stop_next, accept;

    ystep_line_setup #(.CW(CW), .EW(EW)) u_setup (
        .x0_i (x0_i),
        .y0_i (y0_i),
        .x1_i (x1_i),
        .y1_i (y1_i),
        .dx_o (s_dx),
        .dy_o (s_dy),
        .err_o(s_err),
        .sxn_o(s_sxn),
        .syn_o(s_syn)
    );

    ystep_line_step #(.CW(CW), .EW(EW)) u_step (
        .cx_i     (cx_q),
        .cy_i     (cy_q),
        .err_i    (err_q),
        .dx_i     (dx_q),
        .dy_i     (dy_q),
        .sxn_i    (sxn_q),
        .syn_i    (syn_q),
        .nx_o     (n_x),
        .ny_o     (n_y),
        .nerr_o   (n_err),
        .y_moves_o(n_ymove)
    );

    // Emit decision: HOLD releases combinationally when the stop enable drops.
    always_comb begin
        unique case (state_q)
            LN_IDLE: emit = 1'b0;
            LN_DRAW: emit = run_en_i;
            LN_HOLD: emit = run_en_i && !ystop_en_i;
            default: emit = 1'b0;
        endcase
        at_end    = (cx_q == ex_q) && (cy_q == ey_q);
        // A released pixel still obeys the stop policy, so the next row waits again.
        stop_next = (ystop_en_i || (state_q == LN_HOLD)) && (n_ymove || (first_q && hfirst_q));
        accept    = (state_q == LN_IDLE) && start_i;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (start_i) state_d = LN_DRAW;            // T_START
            end
            LN_DRAW, LN_HOLD: begin
                if (emit) begin
                    if (at_end)         state_d = LN_IDLE; // T_LAST
                    else if (stop_next) state_d = LN_HOLD; // T_STOP
                    else                state_d = LN_DRAW; // T_STEP / T_RELEASE
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cx_q     <= '0;
            cy_q     <= '0;
            ex_q     <= '0;
            ey_q     <= '0;
            err_q    <= '0;
            dx_q     <= '0;
            dy_q     <= '0;
            sxn_q    <= 1'b0;
            syn_q    <= 1'b0;
            first_q  <= 1'b0;
            hfirst_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= emit && at_end;
            if (accept) begin
                cx_q     <= x0_i;
                cy_q     <= y0_i;
                ex_q     <= x1_i;
                ey_q     <= y1_i;
                err_q    <= s_err;
                dx_q     <= s_dx;
                dy_q     <= s_dy;
                sxn_q    <= s_sxn;
                syn_q    <= s_syn;
                first_q  <= 1'b1;
                hfirst_q <= hold_first_i;
            end else if (emit) begin
                cx_q    <= n_x;
                cy_q    <= n_y;
                err_q   <= n_err;
                first_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        pix_x_o     = cx_q;
        pix_y_o     = cy_q;
        pix_valid_o = emit;
        busy_o      = (state_q != LN_IDLE);
        ystopped_o  = (state_q == LN_HOLD) && ystop_en_i;
        done_o      = done_q;
    end
endmodule

// File: rtl/ystep_line_raster_chk.sv
`timescale 1ns/1ps
module ystep_line_raster_chk #(
    parameter int CW = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 ystop_en_i,
    input logic signed [CW-1:0] pix_x_o,
    input logic signed [CW-1:0] pix_y_o,
    input logic                 pix_valid_o,
    input logic                 busy_o,
    input logic                 ystopped_o,
    input logic                 done_o
);
    localparam logic signed [CW:0] M1 = '1;
    localparam logic signed [CW:0] P1 = {{CW{1'b0}}, 1'b1};
    localparam logic signed [CW:0] Z0 = '0;

    logic signed [CW-1:0] lx, ly;
    logic                 seen;
    logic signed [CW:0]   ddx, ddy;
    logic                 adj;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lx   <= '0;
            ly   <= '0;
            seen <= 1'b0;
        end else if (!busy_o) begin
            seen <= 1'b0;
        end else if (pix_valid_o) begin
            lx   <= pix_x_o;
            ly   <= pix_y_o;
            seen <= 1'b1;
        end
    end

    always_comb begin
        ddx = $signed({pix_x_o[CW-1], pix_x_o}) - $signed({lx[CW-1], lx});
        ddy = $signed({pix_y_o[CW-1], pix_y_o}) - $signed({ly[CW-1], ly});
        adj = (ddx >= M1) && (ddx <= P1) && (ddy >= M1) && (ddy <= P1) && !((ddx == Z0) && (ddy == Z0));
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
    // R4
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (!busy_o && $past(busy_o)));
    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o);
    // R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) ystopped_o |-> !pix_valid_o);
    // R8
    ystop_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !ystop_en_i |-> !ystopped_o);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> !pix_valid_o);
    // R2
    step_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n) (pix_valid_o && seen) |-> adj);
endmodule

bind ystep_line_raster ystep_line_raster_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ystop_en_i (ystop_en_i),
    .pix_x_o    (pix_x_o),
    .pix_y_o    (pix_y_o),
    .pix_valid_o(pix_valid_o),
    .busy_o     (busy_o),
    .ystopped_o (ystopped_o),
    .done_o     (done_o)
);

// File: tb/ystep_line_raster_bench.sv
`timescale 1ns/1ps
module ystep_line_raster_bench;
    localparam int CLK_PERIOD = 8;
    localparam int CW = 12;
    localparam int NV = 17;
    // x0, y0, x1, y1, stop-on-Y, hold-first, expected hold count
    localparam int VEC [NV][7] = '{
        '{0, 0, 7, 2, 0, 0, 0},
        '{0, 0, 2, 7, 0, 0, 0},
        '{5, 5, -3, 1, 0, 0, 0},
        '{5, 5, 1, -4, 0, 0, 0},
        '{-10, 3, 4, -2, 0, 0, 0},
        '{100, -50, 100, -40, 0, 0, 0},
        '{-7, 9, 9, 9, 0, 0, 0},
        '{3, 3, 3, 3, 0, 0, 0},
        '{0, 0, -6, 6, 0, 0, 0},
        '{2047, -2048, 2040, -2045, 0, 0, 0},
        '{0, 0, 7, 2, 1, 0, 2},
        '{0, 0, 7, 2, 1, 1, 3},
        '{0, 0, 0, 3, 1, 0, 3},
        '{0, 0, 0, 3, 1, 1, 3},
        '{-4, 2, 4, -1, 1, 0, 3},
        '{4, 4, 4, 4, 1, 1, 0},
        '{0, 0, 7, 2, 0, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic start_i;
    logic signed [CW-1:0] x0_i, y0_i, x1_i, y1_i;
    logic run_en_i, ystop_en_i, hold_first_i;
    logic signed [CW-1:0] pix_x_o, pix_y_o;
    logic pix_valid_o, busy_o, ystopped_o, done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ystep_line_raster #(.CW(CW)) u_ystep_line_raster (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .x0_i(x0_i), .y0_i(y0_i), .x1_i(x1_i), .y1_i(y1_i),
        .run_en_i(run_en_i), .ystop_en_i(ystop_en_i), .hold_first_i(hold_first_i),
        .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .pix_valid_o(pix_valid_o),
        .busy_o(busy_o), .ystopped_o(ystopped_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_line(input int x0, input int y0, input int x1, input int y1,
                            input bit use_stop, input bit hf, input int exp_holds,
                            input bit pause, input bit inject);
        int rx, ry, rerr, rdx, rdy, rsx, rsy, e2, npix, nexp, holds, stop_cnt, pause_left, prev_y;
        bit prev_stop, fin, injected;
        string hreq;
        rdx = (x1 > x0) ? x1 - x0 : x0 - x1;
        rdy = -((y1 > y0) ? y1 - y0 : y0 - y1);
        rsx = (x0 < x1) ? 1 : -1;
        rsy = (y0 < y1) ? 1 : -1;
        rerr = rdx + rdy;
        rx = x0; ry = y0;
        nexp = ((rdx > -rdy) ? rdx : -rdy) + 1;
        npix = 0; holds = 0; stop_cnt = 0; pause_left = 3; prev_y = 0;
        prev_stop = 0; fin = 0; injected = 0;
        hreq = hf ? "R9" : "R7";
        @(negedge clk);
        x0_i = CW'(x0); y0_i = CW'(y0); x1_i = CW'(x1); y1_i = CW'(y1);
        hold_first_i = hf; ystop_en_i = use_stop; run_en_i = 1'b1; start_i = 1'b1;
        #1;
        check(!busy_o, "R3", "busy in start cycle", int'(busy_o), 0);
        for (int cyc = 0; cyc < 400 && !fin; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inject && npix == 3 && !injected) begin
                // R5: start while busy, different endpoints
                start_i = 1'b1; x0_i = 12'sd50; y0_i = 12'sd50; x1_i = 12'sd60; y1_i = 12'sd61;
                injected = 1;
            end
            run_en_i = 1'b1;
            if (pause && npix == 2 && pause_left > 0) begin
                run_en_i = 1'b0;
                pause_left--;
            end
            if (use_stop) ystop_en_i = (stop_cnt >= 2) ? 1'b0 : 1'b1;
            #1;
            if (cyc == 0) check(busy_o, "R3", "busy after start", int'(busy_o), 1);
            if (ystopped_o) begin
                if (!prev_stop) holds++;
                stop_cnt++;
                check(!pix_valid_o, "R7", "pixel while y-stopped", int'(pix_valid_o), 0);
            end else begin
                stop_cnt = 0;
            end
            prev_stop = ystopped_o;
            if (use_stop && !ystop_en_i) begin
                check(!ystopped_o, "R8", "stop flag in release cycle", int'(ystopped_o), 0);
                check(pix_valid_o, "R8", "held pixel in release cycle", int'(pix_valid_o), 1);
            end
            if (!run_en_i) check(!pix_valid_o, "R6", "pixel while run disabled", int'(pix_valid_o), 0);
            if (pix_valid_o) begin
                check(int'(pix_x_o) == rx, "R2", "pixel x", int'(pix_x_o), rx);
                check(int'(pix_y_o) == ry, "R2", "pixel y", int'(pix_y_o), ry);
                if (use_stop && ystop_en_i && npix > 0)
                    check(int'(pix_y_o) == prev_y, "R7", "row change without release", int'(pix_y_o), prev_y);
                prev_y = int'(pix_y_o);
                npix++;
                e2 = 2 * rerr;
                if (e2 >= rdy) begin rerr += rdy; rx += rsx; end
                if (e2 <= rdx) begin rerr += rdx; ry += rsy; end
            end
            if (done_o) begin
                check(!busy_o, "R4", "busy in done cycle", int'(busy_o), 0);
                check(npix == nexp, "R2", "pixel count", npix, nexp);
                check(holds == exp_holds, hreq, "hold count", holds, exp_holds);
                fin = 1;
            end
        end
        if (!fin) check(0, "R4", "completion pulse missing", 0, 1);
        @(negedge clk);
        ystop_en_i = 1'b0; run_en_i = 1'b1; start_i = 1'b0;
        #1;
        check(!done_o, "R4", "done wider than one cycle", int'(done_o), 0);
        check(!pix_valid_o, "R10", "pixel while idle", int'(pix_valid_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL R4 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; run_en_i = 1'b1; ystop_en_i = 1'b0; hold_first_i = 1'b0;
        x0_i = '0; y0_i = '0; x1_i = '0; y1_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check(!busy_o && !pix_valid_o && !done_o && !ystopped_o, "R1", "outputs in reset",
              int'({busy_o, pix_valid_o, done_o, ystopped_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy_o && !pix_valid_o && !done_o && !ystopped_o, "R1", "outputs after reset",
              int'({busy_o, pix_valid_o, done_o, ystopped_o}), 0);

        // Vector table
        for (int i = 0; i < NV; i++)
            run_line(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                     VEC[i][4] != 0, VEC[i][5] != 0, VEC[i][6], 1'b0, 1'b0);

        // R5, R6: pause and an ignored start inside one line
        run_line(0, 0, 20, 9, 1'b0, 1'b0, 0, 1'b1, 1'b1);

        // R1: reset in mid-line
        @(negedge clk);
        x0_i = 12'sd0; y0_i = 12'sd0; x1_i = 12'sd30; y1_i = 12'sd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(!busy_o && !pix_valid_o, "R1", "reset in mid-line", int'({busy_o, pix_valid_o}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!busy_o && !pix_valid_o && !done_o, "R1", "idle after mid-line reset",
              int'({busy_o, pix_valid_o, done_o}), 0);

        // The block draws normally after the reset
        run_line(-3, -3, 3, 1, 1'b0, 1'b0, 0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule